// File: doc/BRIEF.md
# MESI data cache line controller

This block keeps the coherence state of a single data cache line and decides which bus action each processor read or write needs. Tag comparison has already been done outside: the request arrives with a hit/miss flag, a byte count, the cacheability signals and the page and line write policy attributes. The block answers with a registered bus command, the length of that transfer, a pulse that tells the data array to take a write, and the line's MESI state with its writeback/writethrough mode.

A request is taken only while `req_ready` is high. A request that needs no bus traffic takes effect in the next cycle. A request that needs a bus cycle keeps its command on `bus_cmd` until the bus side strobes `bus_done`. A line fill needs one strobe per bus-width beat. Any state change that depends on bus traffic is made only when the last strobe arrives. A parameter selects the data-cache behaviour, which is the default, or a reduced instruction-cache variant with only valid (shared) and invalid lines.

Top module: `mesi_line_ctrl`

## Requirements
- R1: A synchronous active-high `rst` gives, on the next cycle, `line_state` invalid (state codes: invalid 00, shared 01, exclusive 10, modified 11), `wb_mode` 0, `bus_cmd` none, `bus_len` 0, `req_ready` 1 and `cache_wr` 0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both high. Its bus command shows on `bus_cmd` in the following cycle. `req_ready` stays low and `bus_cmd` stays unchanged until the command completes. A request presented while `req_ready` is low is ignored.
- R3: A read miss with `cache_req_n` and `cache_en_n` both low issues a line fill (`bus_cmd` code 2) with `bus_len` 32.
- R4: A read miss where either of those two inputs is high issues a single read (code 1) with `bus_len` equal to `req_bytes` (1 to 8). The line state is left unchanged.
- R5: A line fill completes on its fourth `bus_done` strobe. At that point the line becomes exclusive with `wb_mode` 1 if `page_wt` was low and `wb_wt` high at acceptance; otherwise it becomes shared with `wb_mode` 0. `cache_wr` pulses for one cycle after the final strobe.
- R6: A read hit issues no bus command and leaves the state and mode unchanged. A hit flag on an invalid line is treated as a miss.
- R7: A write miss issues a single write (code 3) with `bus_len` equal to `req_bytes`. It does not allocate: the state is unchanged and `cache_wr` stays 0.
- R8: A write hit on a shared line pulses `cache_wr` in the cycle after acceptance and issues a cache-update-plus-write command (code 4). On its `bus_done` strobe the line becomes exclusive with `wb_mode` 1 if `page_wt` was low and `wb_wt` high; otherwise it stays shared with `wb_mode` 0.
- R9: A write hit on an exclusive or modified line issues no bus command, pulses `cache_wr` and makes the line modified with `wb_mode` 1 in the next cycle.
- R10: A `bus_done` strobe while no command is outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hit | input | 1 | Tag lookup hit |
| req_bytes | input | 4 | Byte count of a single access, 1 to 8 |
| cache_req_n | input | 1 | Processor cacheability request, active low |
| cache_en_n | input | 1 | System cache-enable acknowledge, active low |
| page_wt | input | 1 | Page write-through attribute |
| wb_wt | input | 1 | Line policy input, 1 = writeback allowed |
| bus_done | input | 1 | Bus beat/transfer completion strobe |
| req_ready | output | 1 | No command outstanding; request can be taken |
| bus_cmd | output | 3 | 0 none, 1 single read, 2 line fill, 3 single write, 4 update plus write |
| bus_len | output | 6 | Byte length of the outstanding transfer |
| cache_wr | output | 1 | One-cycle data array write pulse |
| line_state | output | 2 | Current MESI state |
| wb_mode | output | 1 | 1 = writeback, 0 = writethrough |

## Verification
The hardest situations to reach from the ports are the deferred commits. A shared line promoted by a write, or a fill ending in exclusive, must hold its old state through a variable gap before `bus_done`, and the line must stay put while new requests and stray strobes press on a busy block. The stimulus first walks the line along a fixed path: a fill in writethrough mode, a shared write hit promoting to exclusive, exclusive to modified, then a writeback fill. It inserts strobe gaps of several lengths and retries requests while the block is busy. A long random phase then drives every input each cycle against the reference model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_t;

   typedef enum logic [2:0] {
      BC_NONE   = 3'd0,
      BC_SREAD  = 3'd1,
      BC_FILL   = 3'd2,
      BC_SWRITE = 3'd3,
      BC_UPDW   = 3'd4
   } bus_cmd_t;

   // outcome of one accepted request
   typedef struct packed {
      bus_cmd_t cmd;
      line_st_t tgt;
      logic     tgt_wb;
      logic     defer;   // commit waits for the bus side
      logic     upd;     // array write in the cycle after acceptance
   } plan_t;

endpackage

// File: rtl/mesi_decide.sv
module mesi_decide
   import mesi_pkg::*;
#(
   parameter bit DCACHE = 1'b1
) (
   input  line_st_t cur_st,
   input  logic     cur_wb,
   input  logic     req_write,
   input  logic     req_hit,
   input  logic     cache_req_n,
   input  logic     cache_en_n,
   input  logic     page_wt,
   input  logic     wb_wt,
   output plan_t    plan
);

   logic hit_eff;
   logic cacheable;
   logic fill_wb;

   assign hit_eff   = req_hit && (cur_st != ST_I);
   assign cacheable = !cache_req_n && !cache_en_n;
   assign fill_wb   = !page_wt && wb_wt;

   generate
      if (DCACHE) begin : g_data
         always_comb begin
            plan = '{cmd: BC_NONE, tgt: cur_st, tgt_wb: cur_wb, defer: 1'b0, upd: 1'b0};
            if (!req_write) begin
               if (!hit_eff) begin
                  plan.defer = 1'b1;
                  if (cacheable) begin
                     plan.cmd    = BC_FILL;
                     plan.tgt    = fill_wb ? ST_E : ST_S;
                     plan.tgt_wb = fill_wb;
                  end else begin
                     plan.cmd = BC_SREAD;
                  end
               end
            end else if (!hit_eff) begin
               plan.cmd   = BC_SWRITE;
               plan.defer = 1'b1;
            end else if (cur_st == ST_S) begin
               plan.cmd    = BC_UPDW;
               plan.defer  = 1'b1;
               plan.upd    = 1'b1;
               plan.tgt    = fill_wb ? ST_E : ST_S;
               plan.tgt_wb = fill_wb;
            end else begin
               plan.upd    = 1'b1;
               plan.tgt    = ST_M;
               plan.tgt_wb = 1'b1;
            end
         end
      end else begin : g_instr
         always_comb begin
            plan = '{cmd: BC_NONE, tgt: cur_st, tgt_wb: 1'b0, defer: 1'b0, upd: 1'b0};
            if (req_write) begin
               plan.cmd   = BC_SWRITE;
               plan.defer = 1'b1;
            end else if (!hit_eff) begin
               plan.defer = 1'b1;
               if (cacheable) begin
                  plan.cmd = BC_FILL;
                  plan.tgt = ST_S;
               end else begin
                  plan.cmd = BC_SREAD;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mesi_beat_cnt.sv
module mesi_beat_cnt #(
   parameter int BEATS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

   logic [CW-1:0] cnt_q;

   assign last = inc && (cnt_q == CW'(BEATS - 1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int LINE_BYTES = 32,
   parameter int BUS_BYTES  = 8,
   parameter bit DCACHE     = 1'b1,
   localparam int BYTE_W    = $clog2(BUS_BYTES + 1),
   localparam int LEN_W     = $clog2(LINE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_hit,
   input  logic [BYTE_W-1:0] req_bytes,
   input  logic              cache_req_n,
   input  logic              cache_en_n,
   input  logic              page_wt,
   input  logic              wb_wt,
   input  logic              bus_done,
   output logic              req_ready,
   output logic [2:0]        bus_cmd,
   output logic [LEN_W-1:0]  bus_len,
   output logic              cache_wr,
   output logic [1:0]        line_state,
   output logic              wb_mode
);

   localparam int BEATS = LINE_BYTES / BUS_BYTES;

   line_st_t         st_q, tgt_q;
   logic             wb_q, tgt_wb_q;
   bus_cmd_t         cmd_q;
   logic [LEN_W-1:0] len_q;
   logic             busy_q;
   logic             upd_q;
   plan_t            plan;
   logic             accept;
   logic             fill_beat;
   logic             fill_last;
   logic             finish;

   mesi_decide #(.DCACHE(DCACHE)) u_decide (
      .cur_st      (st_q),
      .cur_wb      (wb_q),
      .req_write   (req_write),
      .req_hit     (req_hit),
      .cache_req_n (cache_req_n),
      .cache_en_n  (cache_en_n),
      .page_wt     (page_wt),
      .wb_wt       (wb_wt),
      .plan        (plan)
   );

   assign accept    = req_valid && !busy_q;
   assign fill_beat = busy_q && bus_done && (cmd_q == BC_FILL);
   assign finish    = busy_q && bus_done && ((cmd_q != BC_FILL) || fill_last);

   mesi_beat_cnt #(.BEATS(BEATS)) u_beats (
      .clk  (clk),
      .rst  (rst),
      .clr  (accept),
      .inc  (fill_beat),
      .last (fill_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_I;
         wb_q     <= 1'b0;
         tgt_q    <= ST_I;
         tgt_wb_q <= 1'b0;
         cmd_q    <= BC_NONE;
         len_q    <= '0;
         busy_q   <= 1'b0;
         upd_q    <= 1'b0;
      end else begin
         upd_q <= 1'b0;
         if (accept) begin
            upd_q <= plan.upd;
            if (plan.defer) begin
               busy_q   <= 1'b1;
               cmd_q    <= plan.cmd;
               len_q    <= (plan.cmd == BC_FILL) ? LEN_W'(LINE_BYTES) : LEN_W'(req_bytes);
               tgt_q    <= plan.tgt;
               tgt_wb_q <= plan.tgt_wb;
            end else begin
               st_q <= plan.tgt;
               wb_q <= plan.tgt_wb;
            end
         end else if (finish) begin
            busy_q <= 1'b0;
            cmd_q  <= BC_NONE;
            len_q  <= '0;
            st_q   <= tgt_q;
            wb_q   <= tgt_wb_q;
            upd_q  <= (cmd_q == BC_FILL);
         end
      end
   end

   assign req_ready  = !busy_q;
   assign bus_cmd    = cmd_q;
   assign bus_len    = len_q;
   assign cache_wr   = upd_q;
   assign line_state = st_q;
   assign wb_mode    = wb_q;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int LINE_BYTES = 32,
   parameter int BUS_BYTES  = 8,
   parameter bit DCACHE     = 1'b1,
   localparam int BYTE_W    = $clog2(BUS_BYTES + 1),
   localparam int LEN_W     = $clog2(LINE_BYTES + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_hit,
   input logic [BYTE_W-1:0] req_bytes,
   input logic              cache_req_n,
   input logic              cache_en_n,
   input logic              page_wt,
   input logic              wb_wt,
   input logic              bus_done,
   input logic              req_ready,
   input logic [2:0]        bus_cmd,
   input logic [LEN_W-1:0]  bus_len,
   input logic              cache_wr,
   input logic [1:0]        line_state,
   input logic              wb_mode
);

   initial begin
      a_params: assert (BUS_BYTES > 0 && LINE_BYTES >= BUS_BYTES && LINE_BYTES % BUS_BYTES == 0)
         else $error("line size must be a whole number of bus beats");
   end

   logic acc;
   assign acc = req_valid && req_ready;

   // R1
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (line_state == 2'b00 && bus_cmd == 3'd0 && req_ready && !cache_wr));

   // R2
   p_busy_ready_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_cmd != 3'd0) |-> !req_ready);

   // R2
   p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && !bus_done) |=> ($stable(bus_cmd) && $stable(line_state)));

   // R3
   p_fill_len_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_cmd == 3'd2) |-> (bus_len == LEN_W'(LINE_BYTES)));

   // R6
   p_read_hit_r6: assert property (@(posedge clk) disable iff (rst)
      (acc && !req_write && req_hit && line_state != 2'b00) |=>
      ($stable(line_state) && $stable(wb_mode) && bus_cmd == 3'd0));

   // R7
   p_write_miss_r7: assert property (@(posedge clk) disable iff (rst)
      (DCACHE && acc && req_write && (!req_hit || line_state == 2'b00)) |=>
      ($stable(line_state) && bus_cmd == 3'd3 && !cache_wr));

   // R9
   p_em_write_r9: assert property (@(posedge clk) disable iff (rst)
      (DCACHE && acc && req_write && req_hit && line_state[1]) |=>
      (line_state == 2'b11 && wb_mode && bus_cmd == 3'd0 && cache_wr));

   // R10
   p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
      (req_ready && !req_valid && bus_done) |=>
      ($stable(line_state) && $stable(wb_mode) && bus_cmd == 3'd0 && !cache_wr));

   // R5, R8
   p_mode_pair_r5: assert property (@(posedge clk) disable iff (rst)
      (DCACHE && line_state != 2'b00) |-> (wb_mode == line_state[1]));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(
   .LINE_BYTES (LINE_BYTES),
   .BUS_BYTES  (BUS_BYTES),
   .DCACHE     (DCACHE)
) u_chk (.*);

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0, req_write = 1'b0, req_hit = 1'b0;
   logic [3:0] req_bytes = 4'd1;
   logic       cache_req_n = 1'b1, cache_en_n = 1'b1, page_wt = 1'b0, wb_wt = 1'b0;
   logic       bus_done = 1'b0;
   logic       req_ready, cache_wr, wb_mode;
   logic [2:0] bus_cmd;
   logic [5:0] bus_len;
   logic [1:0] line_state;

   always #2 clk = ~clk;

   mesi_line_ctrl dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_hit(req_hit), .req_bytes(req_bytes), .cache_req_n(cache_req_n),
      .cache_en_n(cache_en_n), .page_wt(page_wt), .wb_wt(wb_wt),
      .bus_done(bus_done), .req_ready(req_ready), .bus_cmd(bus_cmd),
      .bus_len(bus_len), .cache_wr(cache_wr), .line_state(line_state),
      .wb_mode(wb_mode)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   bit    finished = 0;
   string tag = "R1";

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_st = 0, m_wb = 0, m_cmd = 0, m_len = 0, m_busy = 0, m_upd = 0;
   int m_beats = 0, m_tst = 0, m_twb = 0;
   bit m_h, m_fw;

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_st = 0; m_wb = 0; m_cmd = 0; m_len = 0; m_busy = 0; m_upd = 0; m_beats = 0;
      end else begin
         m_upd = 0;
         if (m_busy == 0) begin
            if (req_valid) begin
               m_h  = req_hit && (m_st != 0);
               m_fw = !page_wt && wb_wt;
               if (!req_write) begin
                  if (!m_h) begin
                     m_busy = 1;
                     if (!cache_req_n && !cache_en_n) begin
                        m_cmd = 2; m_len = 32; m_beats = 0;
                        m_tst = m_fw ? 2 : 1; m_twb = m_fw;
                     end else begin
                        m_cmd = 1; m_len = req_bytes; m_tst = m_st; m_twb = m_wb;
                     end
                  end
               end else if (!m_h) begin
                  m_busy = 1; m_cmd = 3; m_len = req_bytes; m_tst = m_st; m_twb = m_wb;
               end else if (m_st == 1) begin
                  m_busy = 1; m_cmd = 4; m_len = req_bytes; m_upd = 1;
                  m_tst = m_fw ? 2 : 1; m_twb = m_fw;
               end else begin
                  m_st = 3; m_wb = 1; m_upd = 1;
               end
            end
         end else if (bus_done) begin
            if (m_cmd == 2) m_beats++;
            if (m_cmd != 2 || m_beats == 4) begin
               m_upd  = (m_cmd == 2);
               m_st   = m_tst; m_wb = m_twb;
               m_busy = 0; m_cmd = 0; m_len = 0;
            end
         end
      end
      #1;
      chk(line_state == m_st, tag, line_state, m_st);
      chk(wb_mode == m_wb, tag, wb_mode, m_wb);
      chk(bus_cmd == m_cmd, tag, bus_cmd, m_cmd);
      chk(bus_len == m_len, tag, bus_len, m_len);
      chk(req_ready == (m_busy == 0), tag, req_ready, m_busy == 0);
      chk(cache_wr == m_upd, tag, cache_wr, m_upd);
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 50000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         summary();
      end
   end

   task automatic access(input bit w, input bit h, input int nb, input bit crq,
                         input bit ken, input bit pwt, input bit wbwt);
      @(negedge clk);
      req_valid = 1; req_write = w; req_hit = h; req_bytes = 4'(nb);
      cache_req_n = crq; cache_en_n = ken; page_wt = pwt; wb_wt = wbwt;
      @(negedge clk);
      req_valid = 0;
   endtask

   // drive done strobes with a gap until the block is ready again
   task automatic serve(input int gap);
      while (!req_ready) begin
         repeat (gap) @(negedge clk);
         bus_done = 1;
         @(negedge clk);
         bus_done = 0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(line_state == 0 && req_ready && bus_cmd == 0, "R1", line_state, 0);

      tag = "R7";
      access(1, 0, 4, 0, 0, 0, 1);
      chk(bus_cmd == 3 && bus_len == 4, "R7", bus_cmd, 3);
      serve(2);
      chk(line_state == 0 && !cache_wr, "R7", line_state, 0);

      tag = "R4";
      access(0, 0, 7, 1, 0, 0, 1);
      chk(bus_cmd == 1 && bus_len == 7, "R4", bus_len, 7);
      serve(0);
      access(0, 0, 2, 0, 1, 0, 1);
      chk(bus_cmd == 1, "R4", bus_cmd, 1);
      serve(1);
      chk(line_state == 0, "R4", line_state, 0);

      tag = "R6";
      access(0, 1, 8, 1, 1, 0, 0);
      chk(bus_cmd == 1, "R6", bus_cmd, 1);
      serve(0);

      tag = "R3";
      access(0, 0, 8, 0, 0, 1, 1);
      chk(bus_cmd == 2 && bus_len == 32, "R3", bus_len, 32);
      tag = "R2";
      access(1, 1, 3, 0, 0, 0, 1);
      chk(bus_cmd == 2 && !req_ready, "R2", bus_cmd, 2);
      tag = "R5";
      repeat (3) begin
         @(negedge clk); bus_done = 1; @(negedge clk); bus_done = 0;
      end
      chk(line_state == 0 && bus_cmd == 2, "R5", line_state, 0);
      bus_done = 1; @(negedge clk); bus_done = 0;
      chk(line_state == 1 && wb_mode == 0 && cache_wr, "R5", line_state, 1);

      tag = "R6";
      access(0, 1, 4, 0, 0, 0, 1);
      chk(bus_cmd == 0 && line_state == 1, "R6", line_state, 1);

      tag = "R8";
      access(1, 1, 2, 0, 0, 1, 1);
      chk(bus_cmd == 4 && cache_wr, "R8", bus_cmd, 4);
      serve(3);
      chk(line_state == 1 && !wb_mode, "R8", line_state, 1);
      access(1, 1, 5, 0, 0, 0, 1);
      chk(bus_cmd == 4 && line_state == 1, "R8", line_state, 1);
      serve(2);
      chk(line_state == 2 && wb_mode, "R8", line_state, 2);

      tag = "R9";
      access(1, 1, 1, 0, 0, 1, 0);
      chk(line_state == 3 && wb_mode && cache_wr && bus_cmd == 0, "R9", line_state, 3);
      access(1, 1, 6, 0, 0, 1, 0);
      chk(line_state == 3 && bus_cmd == 0, "R9", line_state, 3);

      tag = "R10";
      @(negedge clk); bus_done = 1; @(negedge clk); bus_done = 0;
      chk(line_state == 3 && bus_cmd == 0 && !cache_wr, "R10", line_state, 3);

      tag = "R5";
      access(0, 0, 8, 0, 0, 0, 1);
      serve(1);
      chk(line_state == 2 && wb_mode, "R5", line_state, 2);

      tag = "R2";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         req_valid   = ($urandom_range(0, 2) == 0);
         req_write   = $urandom_range(0, 1);
         req_hit     = $urandom_range(0, 1);
         req_bytes   = 4'($urandom_range(1, 8));
         cache_req_n = ($urandom_range(0, 3) == 0);
         cache_en_n  = ($urandom_range(0, 3) == 0);
         page_wt     = $urandom_range(0, 1);
         wb_wt       = $urandom_range(0, 1);
         bus_done    = $urandom_range(0, 1);
         rst         = ($urandom_range(0, 499) == 0);
      end
      @(negedge clk);
      req_valid = 0; bus_done = 0; rst = 0;
      repeat (3) @(negedge clk);
      summary();
   end

endmodule